// File: doc/BRIEF.md
# Modifier-aware key event sequencer

This block sits between a producer of logical key requests and a model of a scanned key matrix. Each request names one key together with whether control and shift must be down while it is struck. The sequencer turns every request into single physical events: it first brings the two modifier keys into the state the request needs, then presses the main key and lets it go again. Modifiers that the request needs stay down afterwards. They are released only when a later request does not want them, so a run of shifted characters costs one shift press in total.

Time is counted in scans, not in clock cycles. A scan is a one-cycle pulse on `scan`. At most one event is issued per scan. After each event the block waits a fixed number of scans before the next change, so that debouncing downstream sees stable keys. A request whose keycode is zero is a pause token. It issues no event and holds off all changes for a long, separately set number of scans.

Requests queue in a small FIFO with a valid/ready handshake. The current set of held keys is always visible as a vector indexed by keycode, so it reads in ascending key order at any scan.

Top module: `key_event_seq`

## Requirements
- R1: After reset no key is held (`held_keys` all zero), `ev_valid` is low and `req_ready` is high.
- R2: A request is 9 bits: bits 6:0 hold the keycode, bit 7 asks for shift and bit 8 asks for control. Bit k of `held_keys` is 1 exactly while key k is down. Each event sets or clears that one bit, and the same clock edge shows it on `ev_valid`/`ev_press`/`ev_code`.
- R3: Control is physical key 0x7C and shift is key 0x7D. Before the main key, a held modifier the request does not need is released, control before shift. A needed modifier that is not held is then pressed, control before shift.
- R4: The main key is pressed on one event and released on the next. Modifiers that the request needs remain held after the request ends.
- R5: After any event, the next 10 scans carry no change. The earliest following event comes on the 11th scan.
- R6: A request with keycode 0 issues no event and ignores its flag bits. The 100 scans after it carry no change.
- R7: Changes happen only at a scan edge, at most one per scan. `ev_valid` is high for the single cycle after that edge, and `held_keys` does not move between scans.
- R8: Up to 8 requests wait in the queue, plus one in service. `req_ready` is low while the queue is full. A request offered while it is low has no effect. Accepted requests are served in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_data | input | 9 | Request: control, shift, keycode |
| req_ready | output | 1 | Queue can accept a request |
| scan | input | 1 | One-cycle scan pulse |
| ev_valid | output | 1 | An event occurred at the last scan |
| ev_press | output | 1 | 1 = press, 0 = release |
| ev_code | output | 7 | Key affected by the event |
| held_keys | output | 128 | Held-key vector indexed by keycode |

## Verification
A wrong modifier record shows up at `held_keys` bits 0x7C/0x7D. It also shows as an unexpected modifier event, at the first scan that serves the next request. A stuck or miscounted pacing counter moves an event one scan early or late, and the bench sees this at the exact scan where it happens. Lost, duplicated or reordered queue entries show as a mismatch in the event stream once the queue drains.

// File: rtl/key_seq_pkg.sv
package key_seq_pkg;
  localparam int CODE_W = 7;
  localparam int REQ_W  = CODE_W + 2;
  localparam int NKEYS  = 1 << CODE_W;
  localparam logic [CODE_W-1:0] CTRL_CODE  = 7'h7C;
  localparam logic [CODE_W-1:0] SHIFT_CODE = 7'h7D;

  typedef struct packed {
    logic              act;
    logic              press;
    logic [CODE_W-1:0] code;
  } key_step_t;

  typedef enum logic {PH_PREP, PH_LIFT} seq_phase_t;

  // Next modifier correction; releases first (ctrl, shift), then presses.
  function automatic key_step_t mod_step(input logic c_held, input logic s_held,
                                         input logic c_need, input logic s_need);
    key_step_t s;
    s = '0;
    if (c_held && !c_need) begin
      s.act = 1'b1; s.press = 1'b0; s.code = CTRL_CODE;
    end else if (s_held && !s_need) begin
      s.act = 1'b1; s.press = 1'b0; s.code = SHIFT_CODE;
    end else if (c_need && !c_held) begin
      s.act = 1'b1; s.press = 1'b1; s.code = CTRL_CODE;
    end else if (s_need && !s_held) begin
      s.act = 1'b1; s.press = 1'b1; s.code = SHIFT_CODE;
    end
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] req_code(input logic [REQ_W-1:0] r);
    return r[CODE_W-1:0];
  endfunction
  function automatic logic req_shift(input logic [REQ_W-1:0] r);
    return r[CODE_W];
  endfunction
  function automatic logic req_ctrl(input logic [REQ_W-1:0] r);
    return r[CODE_W+1];
  endfunction
endpackage

// File: rtl/key_seq_fifo.sv
module key_seq_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/key_seq_pacer.sv
module key_seq_pacer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             idle
);
  logic [CNT_W-1:0] cnt;

  assign idle = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (scan) begin
      if (load)            cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  a_r5_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (scan && idle));
  a_r7_still_between_scans: assert property (@(posedge clk) disable iff (!rst_n)
    !scan |=> $stable(cnt));
endmodule

// File: rtl/key_event_seq.sv
module key_event_seq
  import key_seq_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int HOLD_SCANS  = 10,
  parameter int DELAY_SCANS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [8:0]        req_data,
  output logic              req_ready,
  input  logic              scan,
  output logic              ev_valid,
  output logic              ev_press,
  output logic [6:0]        ev_code,
  output logic [127:0]      held_keys
);
  localparam int LONGEST = (DELAY_SCANS > HOLD_SCANS) ? DELAY_SCANS : HOLD_SCANS;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  // Named internal events
  logic             fifo_full, fifo_empty, fifo_pop;
  logic [REQ_W-1:0] fifo_dout;
  logic             cur_valid;
  logic [REQ_W-1:0] cur_req;
  seq_phase_t       phase;
  logic             pace_idle, pace_load;
  logic [CNT_W-1:0] pace_val;
  logic             step_ok, delay_tok;
  logic             ev_fire, ev_press_n, to_lift, req_done;
  logic [CODE_W-1:0] ev_code_n;
  key_step_t        mstep;

  assign req_ready = !fifo_full;
  assign fifo_pop  = !cur_valid && !fifo_empty;

  key_seq_fifo #(.WIDTH(REQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(req_valid), .din(req_data),
    .pop(fifo_pop), .dout(fifo_dout),
    .full(fifo_full), .empty(fifo_empty)
  );

  key_seq_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .scan(scan),
    .load(pace_load), .load_val(pace_val), .idle(pace_idle)
  );

  assign step_ok   = scan && pace_idle && cur_valid;
  assign delay_tok = (req_code(cur_req) == '0);
  assign mstep     = mod_step(held_keys[CTRL_CODE], held_keys[SHIFT_CODE],
                              req_ctrl(cur_req), req_shift(cur_req));

  always_comb begin
    ev_fire    = 1'b0;
    ev_press_n = 1'b0;
    ev_code_n  = '0;
    pace_load  = 1'b0;
    pace_val   = CNT_W'(HOLD_SCANS);
    to_lift    = 1'b0;
    req_done   = 1'b0;
    if (step_ok) begin
      pace_load = 1'b1;
      if (delay_tok) begin
        pace_val = CNT_W'(DELAY_SCANS);
        req_done = 1'b1;
      end else if (phase == PH_LIFT) begin
        ev_fire   = 1'b1;
        ev_code_n = req_code(cur_req);
        req_done  = 1'b1;
      end else if (mstep.act) begin
        ev_fire    = 1'b1;
        ev_press_n = mstep.press;
        ev_code_n  = mstep.code;
      end else begin
        ev_fire    = 1'b1;
        ev_press_n = 1'b1;
        ev_code_n  = req_code(cur_req);
        to_lift    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_req   <= '0;
      phase     <= PH_PREP;
      held_keys <= '0;
      ev_valid  <= 1'b0;
      ev_press  <= 1'b0;
      ev_code   <= '0;
    end else begin
      if (fifo_pop) begin
        cur_valid <= 1'b1;
        cur_req   <= fifo_dout;
        phase     <= PH_PREP;
      end else if (req_done) begin
        cur_valid <= 1'b0;
      end else if (to_lift) begin
        phase <= PH_LIFT;
      end
      if (ev_fire) held_keys[ev_code_n] <= ev_press_n;
      ev_valid <= ev_fire;
      ev_press <= ev_press_n;
      ev_code  <= ev_code_n;
    end
  end

  // Scans since the last change, saturating at the hold count
  logic [CNT_W-1:0] since_ev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_ev <= CNT_W'(HOLD_SCANS);
    else if (ev_fire) since_ev <= '0;
    else if (scan && since_ev < CNT_W'(HOLD_SCANS)) since_ev <= since_ev + 1'b1;
  end

  a_r2_held_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> (held_keys[$past(ev_code_n)] == $past(ev_press_n)));
  a_r3_mods_before_main: assert property (@(posedge clk) disable iff (!rst_n)
    to_lift |-> (held_keys[CTRL_CODE] == req_ctrl(cur_req) &&
                 held_keys[SHIFT_CODE] == req_shift(cur_req)));
  a_r4_mods_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && !delay_tok) |=> (held_keys[CTRL_CODE] == req_ctrl($past(cur_req)) &&
                                  held_keys[SHIFT_CODE] == req_shift($past(cur_req))));
  a_r5_hold_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |-> (since_ev >= CNT_W'(HOLD_SCANS)));
  a_r6_delay_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && delay_tok) |=> (!ev_valid && $stable(held_keys)));
  a_r7_one_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);
endmodule

// File: tb/key_event_seq_test.sv
module key_event_seq_test;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req_valid = 1'b0, scan = 1'b0;
  logic [8:0]   req_data = '0;
  logic         req_ready, ev_valid, ev_press;
  logic [6:0]   ev_code;
  logic [127:0] held_keys;

  key_event_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_ready(req_ready), .scan(scan), .ev_valid(ev_valid), .ev_press(ev_press),
    .ev_code(ev_code), .held_keys(held_keys)
  );

  always #10 clk = ~clk;

  int           checks = 0, errors = 0;
  bit           finished = 0;
  logic [8:0]   exp_q[$];   // {kind[1:0], code}: 0 press, 1 release, 2 pause
  logic [127:0] m_held = '0;
  int           m_timer = 0;
  bit           plan_c = 0, plan_s = 0;

  task automatic chk(input bit ok, input string tag, input logic [136:0] act,
                     input logic [136:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expand one accepted request into its expected event list
  function automatic void plan(input logic [8:0] r);
    if (r[6:0] == 7'd0) begin
      exp_q.push_back({2'd2, 7'd0});
      return;
    end
    if (plan_c && !r[8]) begin exp_q.push_back({2'd1, 7'h7C}); plan_c = 0; end
    if (plan_s && !r[7]) begin exp_q.push_back({2'd1, 7'h7D}); plan_s = 0; end
    if (r[8] && !plan_c) begin exp_q.push_back({2'd0, 7'h7C}); plan_c = 1; end
    if (r[7] && !plan_s) begin exp_q.push_back({2'd0, 7'h7D}); plan_s = 1; end
    exp_q.push_back({2'd0, r[6:0]});
    exp_q.push_back({2'd1, r[6:0]});
  endfunction

  task automatic push_req(input logic [8:0] r, output bit acc);
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = r;
    acc = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
    if (acc) plan(r);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_scan();
    logic       e_valid, e_press;
    logic [6:0] e_code;
    logic [8:0] e;
    string      tag;
    e_valid = 0; e_press = 0; e_code = '0;
    @(negedge clk) scan = 1'b1;
    @(negedge clk) scan = 1'b0;
    if (m_timer > 0) begin
      m_timer--;
      tag = "R5 hold";
    end else if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      if (e[8:7] == 2'd2) begin
        m_timer = 100;
        tag = "R6 pause";
      end else begin
        e_valid = 1; e_press = (e[8:7] == 2'd0); e_code = e[6:0];
        m_held[e_code] = e_press;
        m_timer = 10;
        tag = (e_code == 7'h7C || e_code == 7'h7D) ? "R3 modifier" : "R4 main key";
      end
    end else tag = "R7 idle scan";
    chk(ev_valid == e_valid && (!e_valid || (ev_press == e_press && ev_code == e_code))
        && held_keys == m_held, tag,
        {ev_valid, ev_valid ? {ev_press, ev_code} : 8'h0, held_keys},
        {e_valid, e_valid ? {e_press, e_code} : 8'h0, m_held});
    repeat (3) @(negedge clk);
    chk(!ev_valid && held_keys == m_held, "R7 quiet between scans",
        {ev_valid, 8'h0, held_keys}, {1'b0, 8'h0, m_held});
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() > 0 || m_timer > 0) && guard < 5000) begin
      do_scan();
      guard++;
    end
    do_scan();
  endtask

  initial begin
    bit acc;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(held_keys == '0 && !ev_valid && req_ready, "R1 reset state",
        {ev_valid, 7'h0, req_ready, held_keys}, {1'b0, 7'h0, 1'b1, 128'h0});

    // Directed: shifted key, then unshifted (R2, R3, R4)
    push_req(9'h080 | 9'h1A, acc); drain();
    chk(held_keys == (128'h1 << 7'h7D), "R4 shift stays held",
        {9'h0, held_keys}, {9'h0, 128'h1 << 7'h7D});
    push_req(9'h080 | 9'h21, acc); drain();
    push_req(9'h01A, acc); drain();
    chk(held_keys == '0, "R3 shift released", {9'h0, held_keys}, {9'h0, 128'h0});
    push_req(9'h180 | 9'h22, acc); drain();
    push_req(9'h100 | 9'h23, acc); drain();
    // Pause token with flags set while control is held: flags ignored (R6)
    push_req(9'h180, acc); drain();
    chk(held_keys == (128'h1 << 7'h7C), "R6 pause ignores flags",
        {9'h0, held_keys}, {9'h0, 128'h1 << 7'h7C});
    push_req(9'h005, acc); drain();

    // Back-pressure: 8 queued + 1 in service, then refused (R8)
    for (int i = 0; i < 9; i++) begin
      push_req(9'(i + 9'h40) | ((i % 2) ? 9'h080 : 9'h000), acc);
      chk(acc, "R8 accept while room", {136'h0, acc}, {136'h0, 1'b1});
    end
    chk(!req_ready, "R8 ready low when full", {136'h0, req_ready}, {136'h0, 1'b0});
    push_req(9'h133, acc);
    chk(!acc, "R8 refused request", {136'h0, acc}, {136'h0, 1'b0});
    drain();
    chk(req_ready, "R8 ready after drain", {136'h0, req_ready}, {136'h0, 1'b1});

    // Constrained random batches
    for (int b = 0; b < 40; b++) begin
      int n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        logic [8:0] r;
        r[6:0] = ($urandom % 8 == 0) ? 7'd0 : 7'(1 + ($urandom % 7'h7B));
        r[7]   = 1'($urandom);
        r[8]   = 1'($urandom);
        push_req(r, acc);
        chk(acc, "R8 accept random", {136'h0, acc}, {136'h0, 1'b1});
      end
      drain();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule